// File: doc/BRIEF.md
# Address Compare Stop Controller

This block watches the storage address register and compares it with an address set on maintenance switches. A storage-select input decides whether main-storage or control-storage accesses are compared. Each access strobe that carries the selected storage type and an address equal to the switch setting is a qualifying match. Every qualifying match produces a one-cycle sync pulse that a scope or a logic analyser can trigger on.

In run mode the sync pulse is the only effect, and the machine keeps running. In stop mode the machine also halts. The kind of halt depends on the storage type. A main-storage match waits for the current system instruction to finish and then requests the microprogram stop loop, which also turns on the stop light. The loop is left when the operator START key is pressed. A control-storage match turns the processor clock enable off once the matched microinstruction has executed. This does not happen when the match falls inside an I/O operation. The clock enable comes back only on the engineer's START key.

The controller itself runs on a free-running clock, so that the engineer's START key still works while the processor clock is gated.

Top module: `addr_cmp_stop`

## Requirements
- R1: After reset, sync_pulse, stop_loop_req and stop_light are 0 and clk_en is 1.
- R2: An access strobe that qualifies (acc_vld=1, sar equal to sw_addr, acc_ctrl equal to sel_ctrl) drives sync_pulse to 1 for exactly the cycle after the strobe, in both modes.
- R3: An access whose storage type (acc_ctrl: 0 main, 1 control) differs from sel_ctrl, or whose address differs from sw_addr, produces neither a sync pulse nor any stop.
- R4: With mode_stop=0, a qualifying match never raises stop_loop_req and never clears clk_en.
- R5: With mode_stop=1 and a main-storage match, stop_loop_req and stop_light rise in the cycle after the first instr_done pulse seen at or after the match cycle. This includes an instr_done in the match cycle itself.
- R6: Once raised, stop_loop_req stays at 1 until start_key is sampled at 1, and then falls in the next cycle. ce_start_key has no effect on it.
- R7: With mode_stop=1 and a control-storage match, clk_en falls in the cycle after the first uinst_done pulse seen at or after the match cycle. This includes a uinst_done in the match cycle itself.
- R8: A control-storage match sampled while io_active=1 still pulses sync_pulse, but it neither gates the clock nor leaves a pending stop for a later uinst_done.
- R9: A gated clk_en returns to 1 in the cycle after ce_start_key is sampled at 1. start_key has no effect on it.
- R10: A match that arrives while a stop of the same kind is pending or active neither extends nor renews it. A match in the same cycle as the releasing key leaves the block released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_stop | input | 1 | 0 run mode, 1 stop mode |
| sel_ctrl | input | 1 | Storage compared: 0 main, 1 control |
| sw_addr | input | ADDR_W | Switch-set compare address |
| sar | input | ADDR_W | Storage address register value |
| acc_vld | input | 1 | Storage access strobe |
| acc_ctrl | input | 1 | Storage type of the access: 0 main, 1 control |
| instr_done | input | 1 | Current system instruction completes this cycle |
| uinst_done | input | 1 | Current microinstruction completes this cycle |
| io_active | input | 1 | An I/O operation is in progress |
| start_key | input | 1 | Operator START key |
| ce_start_key | input | 1 | Engineer START key |
| sync_pulse | output | 1 | One-cycle match pulse |
| stop_loop_req | output | 1 | Request to enter the microprogram stop loop |
| clk_en | output | 1 | Processor clock enable |
| stop_light | output | 1 | Stop indicator |

## Verification
Two pairs of events can land in the same cycle. The first is a match and the completion that finishes it: a main-storage hit with instr_done, or a control-storage hit with uinst_done. The bench drives both in one cycle and expects the stop one cycle later, with no wait for a further completion. The second is a match and the key that releases a stop: the bench presents a fresh hit together with start_key while the stop loop is active. It then checks that the loop drops and stays down for the following cycles.

// File: rtl/acs_pkg.sv
package acs_pkg;
   // Three-phase life of one stop mechanism
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PEND = 2'd1,
      ST_HALT = 2'd2
   } stop_state_e;
endpackage

// File: rtl/acs_match.sv
module acs_match #(
   parameter int ADDR_W   = 16,
   parameter bit SYNC_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_ctrl,
   input  logic [ADDR_W-1:0] sw_addr,
   input  logic [ADDR_W-1:0] sar,
   input  logic              acc_vld,
   input  logic              acc_ctrl,
   output logic              hit_main,
   output logic              hit_ctrl,
   output logic              sync_pulse
);
   logic hit;

   assign hit      = acc_vld && (acc_ctrl == sel_ctrl) && (sar == sw_addr);
   assign hit_main = hit && !acc_ctrl;
   assign hit_ctrl = hit && acc_ctrl;

   generate
      if (SYNC_REG) begin : g_sync_ff
         logic sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= 1'b0;
            else        sync_q <= hit;
         end
         assign sync_pulse = sync_q;
      end else begin : g_sync_comb
         assign sync_pulse = hit;
      end
   endgenerate
endmodule

// File: rtl/acs_stop_fsm.sv
module acs_stop_fsm
   import acs_pkg::*;
#(
   parameter bit HALT_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic boundary,
   input  logic release_key,
   output logic halt_out
);
   stop_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (arm)         state_d = boundary ? ST_HALT : ST_PEND;
         ST_PEND: if (boundary)    state_d = ST_HALT;
         ST_HALT: if (release_key) state_d = ST_IDLE;
         default:                  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign halt_out = (state_q == ST_HALT) ? HALT_LEVEL : ~HALT_LEVEL;
endmodule

// File: rtl/addr_cmp_stop.sv
module addr_cmp_stop #(
   parameter int ADDR_W   = 16,
   parameter bit SYNC_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_stop,
   input  logic              sel_ctrl,
   input  logic [ADDR_W-1:0] sw_addr,
   input  logic [ADDR_W-1:0] sar,
   input  logic              acc_vld,
   input  logic              acc_ctrl,
   input  logic              instr_done,
   input  logic              uinst_done,
   input  logic              io_active,
   input  logic              start_key,
   input  logic              ce_start_key,
   output logic              sync_pulse,
   output logic              stop_loop_req,
   output logic              clk_en,
   output logic              stop_light
);
   generate
      if (ADDR_W < 1) begin : g_bad_width
         $error("addr_cmp_stop: ADDR_W must be at least 1");
      end
   endgenerate

   logic hit_main, hit_ctrl;
   logic arm_main, arm_ctrl;

   acs_match #(.ADDR_W(ADDR_W), .SYNC_REG(SYNC_REG)) i_match (
      .clk(clk), .rst_n(rst_n), .sel_ctrl(sel_ctrl), .sw_addr(sw_addr),
      .sar(sar), .acc_vld(acc_vld), .acc_ctrl(acc_ctrl),
      .hit_main(hit_main), .hit_ctrl(hit_ctrl), .sync_pulse(sync_pulse)
   );

   assign arm_main = mode_stop && hit_main;
   assign arm_ctrl = mode_stop && hit_ctrl && !io_active;

   // Main storage: stop at the system instruction boundary
   acs_stop_fsm #(.HALT_LEVEL(1'b1)) i_main_stop (
      .clk(clk), .rst_n(rst_n), .arm(arm_main), .boundary(instr_done),
      .release_key(start_key), .halt_out(stop_loop_req)
   );

   // Control storage: gate the clock after the matched microinstruction
   acs_stop_fsm #(.HALT_LEVEL(1'b0)) i_ctrl_stop (
      .clk(clk), .rst_n(rst_n), .arm(arm_ctrl), .boundary(uinst_done),
      .release_key(ce_start_key), .halt_out(clk_en)
   );

   assign stop_light = stop_loop_req;
endmodule

// File: rtl/addr_cmp_stop_chk.sv
module addr_cmp_stop_chk (
   input logic clk,
   input logic rst_n,
   input logic acc_vld,
   input logic instr_done,
   input logic uinst_done,
   input logic start_key,
   input logic ce_start_key,
   input logic mode_stop,
   input logic sync_pulse,
   input logic stop_loop_req,
   input logic clk_en
);
   AST_SYNC_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      sync_pulse |-> $past(acc_vld)); // R2

   AST_LOOP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stop_loop_req) |-> $past(instr_done) && $past(mode_stop)); // R5

   AST_LOOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stop_loop_req) |-> $past(start_key)); // R6

   AST_GATE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_en) |-> $past(uinst_done)); // R7

   AST_GATE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_en) |-> $past(ce_start_key)); // R9
endmodule

bind addr_cmp_stop addr_cmp_stop_chk i_chk (
   .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .instr_done(instr_done),
   .uinst_done(uinst_done), .start_key(start_key), .ce_start_key(ce_start_key),
   .mode_stop(mode_stop), .sync_pulse(sync_pulse),
   .stop_loop_req(stop_loop_req), .clk_en(clk_en)
);

// File: tb/test_addr_cmp_stop.sv
module test_addr_cmp_stop;
   localparam int AW = 16;
   localparam logic [AW-1:0] SW = 16'h1A2B;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_stop = 1'b0, sel_ctrl = 1'b0;
   logic [AW-1:0] sw_addr = SW, sar = '0;
   logic acc_vld = 1'b0, acc_ctrl = 1'b0;
   logic instr_done = 1'b0, uinst_done = 1'b0, io_active = 1'b0;
   logic start_key = 1'b0, ce_start_key = 1'b0;
   logic sync_pulse, stop_loop_req, clk_en, stop_light;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   addr_cmp_stop #(.ADDR_W(AW)) i_addr_cmp_stop (
      .clk(clk), .rst_n(rst_n), .mode_stop(mode_stop), .sel_ctrl(sel_ctrl),
      .sw_addr(sw_addr), .sar(sar), .acc_vld(acc_vld), .acc_ctrl(acc_ctrl),
      .instr_done(instr_done), .uinst_done(uinst_done), .io_active(io_active),
      .start_key(start_key), .ce_start_key(ce_start_key),
      .sync_pulse(sync_pulse), .stop_loop_req(stop_loop_req),
      .clk_en(clk_en), .stop_light(stop_light)
   );

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic quiet();
      acc_vld = 0; acc_ctrl = 0; sar = '0; instr_done = 0; uinst_done = 0;
      io_active = 0; start_key = 0; ce_start_key = 0;
   endtask

   task automatic access(input logic ctrl, input logic [AW-1:0] a);
      acc_vld = 1; acc_ctrl = ctrl; sar = a;
   endtask

   task automatic t_reset();
      chk("R1", "sync", sync_pulse, 1'b0);
      chk("R1", "stop_loop", stop_loop_req, 1'b0);
      chk("R1", "clk_en", clk_en, 1'b1);
      chk("R1", "light", stop_light, 1'b0);
   endtask

   task automatic t_run_mode();
      mode_stop = 0; sel_ctrl = 0;
      access(1'b0, SW); instr_done = 1; step(); quiet();
      chk("R2", "sync after main hit", sync_pulse, 1'b1);
      chk("R4", "no loop in run", stop_loop_req, 1'b0);
      step();
      chk("R2", "sync single cycle", sync_pulse, 1'b0);
      instr_done = 1; step(); quiet();
      chk("R4", "no loop later", stop_loop_req, 1'b0);
      sel_ctrl = 1;
      access(1'b1, SW); uinst_done = 1; step(); quiet();
      chk("R2", "sync after ctrl hit", sync_pulse, 1'b1);
      chk("R4", "clock kept in run", clk_en, 1'b1);
      step();
      chk("R4", "clock kept later", clk_en, 1'b1);
   endtask

   task automatic t_select();
      mode_stop = 1; sel_ctrl = 0;
      access(1'b1, SW); uinst_done = 1; instr_done = 1; step(); quiet();
      chk("R3", "wrong type no sync", sync_pulse, 1'b0);
      chk("R3", "wrong type no gate", clk_en, 1'b1);
      chk("R3", "wrong type no loop", stop_loop_req, 1'b0);
      access(1'b0, SW ^ 16'h0001); instr_done = 1; step(); quiet();
      chk("R3", "wrong addr no sync", sync_pulse, 1'b0);
      chk("R3", "wrong addr no loop", stop_loop_req, 1'b0);
      sel_ctrl = 1;
      access(1'b0, SW); instr_done = 1; step(); quiet();
      chk("R3", "main hit under ctrl select", stop_loop_req, 1'b0);
      chk("R3", "main hit under ctrl select sync", sync_pulse, 1'b0);
   endtask

   task automatic t_main_stop();
      mode_stop = 1; sel_ctrl = 0;
      access(1'b0, SW); step(); quiet();
      chk("R2", "sync in stop mode", sync_pulse, 1'b1);
      chk("R5", "no loop before boundary", stop_loop_req, 1'b0);
      step(); step();
      chk("R5", "still waiting", stop_loop_req, 1'b0);
      access(1'b0, SW); step(); quiet();
      chk("R10", "second hit while pending", stop_loop_req, 1'b0);
      instr_done = 1; step(); quiet();
      chk("R5", "loop after boundary", stop_loop_req, 1'b1);
      chk("R5", "light on", stop_light, 1'b1);
      step(); step();
      chk("R6", "loop held", stop_loop_req, 1'b1);
      ce_start_key = 1; step(); quiet();
      chk("R6", "ce start ignored", stop_loop_req, 1'b1);
      access(1'b0, SW); instr_done = 1; start_key = 1; step(); quiet();
      chk("R10", "released despite hit", stop_loop_req, 1'b0);
      step(); step();
      chk("R10", "stays released", stop_loop_req, 1'b0);
      chk("R6", "light off", stop_light, 1'b0);
      access(1'b0, SW); instr_done = 1; step(); quiet();
      chk("R5", "same-cycle boundary", stop_loop_req, 1'b1);
      start_key = 1; step(); quiet();
      chk("R6", "start releases", stop_loop_req, 1'b0);
   endtask

   task automatic t_ctrl_stop();
      mode_stop = 1; sel_ctrl = 1;
      access(1'b1, SW); uinst_done = 1; step(); quiet();
      chk("R7", "gate same-cycle", clk_en, 1'b0);
      chk("R2", "sync with gate", sync_pulse, 1'b1);
      start_key = 1; step(); quiet();
      chk("R9", "operator start ignored", clk_en, 1'b0);
      chk("R9", "no loop from ctrl", stop_loop_req, 1'b0);
      ce_start_key = 1; step(); quiet();
      chk("R9", "ce start resumes", clk_en, 1'b1);
      access(1'b1, SW); step(); quiet();
      chk("R7", "waits for uinst", clk_en, 1'b1);
      step();
      chk("R7", "still waiting", clk_en, 1'b1);
      uinst_done = 1; step(); quiet();
      chk("R7", "gate after uinst", clk_en, 1'b0);
      ce_start_key = 1; step(); quiet();
      chk("R9", "resume again", clk_en, 1'b1);
   endtask

   task automatic t_io();
      mode_stop = 1; sel_ctrl = 1;
      access(1'b1, SW); io_active = 1; uinst_done = 1; step(); quiet();
      chk("R8", "sync during io", sync_pulse, 1'b1);
      chk("R8", "no gate during io", clk_en, 1'b1);
      uinst_done = 1; step(); quiet();
      chk("R8", "no pending after io", clk_en, 1'b1);
      step();
      chk("R8", "still running", clk_en, 1'b1);
   endtask

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_run_mode();
      t_select();
      t_main_stop();
      t_ctrl_stop();
      t_io();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule